// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing protocol engine of a serial memory that sits on a two-wire (I2C-style) bus as a slave. It takes the raw clock and data lines and brings them into the system clock domain. It recognises start and stop conditions and receives bytes most significant bit first. The block answers its device address and, for a write, gathers a two-byte word address followed by any number of data bytes. Each accepted byte is acknowledged by pulling the data line low during the ninth clock.

Data bytes reach the storage behind the block through a one-cycle write strobe that carries the address and the data. A stop that closes a write with at least one data byte raises a commit pulse, which tells the storage to start its internal programming cycle. While the storage reports that cycle as running, the block refuses its device address and answers no traffic. The read data path is not part of this block: a read request is acknowledged, and the block then stays silent until the next start.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After a start, the first byte is taken MSB first as the device word `{5'b10100, strap[1:0], rw}`. When the word matches and no write cycle is pending, `sda_pull` is 1 during the ninth SCL high phase.
- R2: If the top five bits differ from 10100, no acknowledge is given for that byte or for any later byte, and no write strobe or commit occurs until the next start.
- R3: The two bits after the prefix must equal `strap`. A mismatch gives no acknowledge and no write activity, and the same word is accepted once `strap` matches it.
- R4: For a write (rw = 0), the next two bytes are the high and low word-address bytes, and each is acknowledged. The start address is `{high, low}` reduced to its low ADDR_W bits.
- R5: Every data byte after the address bytes is acknowledged and gives one `mem_we` pulse carrying the current address and the byte.
- R6: After each data byte only the low PAGE_W address bits advance, wrapping from the last location of the page to its first. The upper bits stay unchanged.
- R7: A stop that follows at least one complete data byte gives exactly one `wr_commit` pulse. A stop with no complete data byte gives none.
- R8: While `wr_busy` is 1 the device word is not acknowledged for either value of rw, and nothing is written. Once `wr_busy` returns to 0, a write is acknowledged again.
- R9: A read device word (rw = 1) that matches is acknowledged. Afterwards the block pulls nothing and writes nothing until the next start.
- R10: A start or stop in the middle of a byte aborts the transfer. After a new start, a full transfer is received correctly from its first bit, and a byte cut short by a stop is neither written nor committed.
- R11: `sda_pull` changes only while the synchronised SCL is low, and it is 0 during the high phase of every bit that the master drives.
- R12: After reset, `sda_pull`, `mem_we` and `wr_commit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| strap | input | 2 | Board strap bits for the device word; a floating pin is tied to 0 outside |
| wr_busy | input | 1 | Storage reports an internal write cycle running |
| sda_pull | output | 1 | Pull-low enable for the open-drain data line |
| mem_we | output | 1 | One-cycle write strobe per received data byte |
| mem_addr | output | ADDR_W | Byte address for `mem_we` |
| mem_wdata | output | 8 | Data byte for `mem_we` |
| wr_commit | output | 1 | One-cycle pulse: a write ended by stop, start programming |

## Verification
The device word is exercised with a matching write, a matching read, a wrong fixed prefix, a wrong strap value and a matching word while busy. These cases separate the prefix compare, the strap compare, the rw split and the busy gate. Write transfers with one byte and with several bytes starting two locations before a page end show apart a plain address load and the in-page wrap. Transfers cut by a start or a stop after a few bits check that the bit counter restarts and that partial bytes never reach the storage.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int BYTE_BITS = 8;
  localparam logic [4:0] DEV_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WA_HI,
    ST_WA_LO,
    ST_DATA,
    ST_SKIP
  } twi_state_e;

  // device word layout: [7:3] fixed prefix, [2:1] strap, [0] rw
  function automatic logic dev_match(input logic [7:0] word, input logic [1:0] strap);
    return (word[7:3] == DEV_PREFIX) && (word[2:1] == strap);
  endfunction

  function automatic logic is_read(input logic [7:0] word);
    return word[0];
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '1;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '1;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // conditions need SCL high on both samples so an edge of SCL is never mistaken for one
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic              advance,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] ptr
);

  logic [7:0] hi_q;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      ptr  <= '0;
    end else begin
      if (load_hi) hi_q <= din;
      if (load_lo)      ptr <= ADDR_W'({hi_q, din});
      else if (advance) ptr <= page_next(ptr);
    end
  end

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        strap,
  input  logic              wr_busy,
  output logic              sda_pull,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              wr_commit
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic [1:0] raw_lines, sync_lines;
  logic       scl_q, sda_q;
  logic       start_evt, stop_evt, scl_rise, scl_fall;

  assign raw_lines = {scl_in, sda_in};

  twi_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_lines),
    .q    (sync_lines)
  );

  assign scl_q = sync_lines[1];
  assign sda_q = sync_lines[0];

  twi_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_q),
    .sda_s    (sda_q),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  twi_state_e       state;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             ack_phase;
  logic             have_data;

  // named internal events
  logic receiving, byte_done, ack_end, shift_en, dev_byte_done, dev_ok;
  logic ld_hi, ld_lo, adv;
  logic [ADDR_W-1:0] ptr;

  assign receiving     = (state == ST_DEV) || (state == ST_WA_HI) ||
                         (state == ST_WA_LO) || (state == ST_DATA);
  assign byte_done     = scl_fall & receiving & ~ack_phase & (bitcnt == FULL);
  assign ack_end       = scl_fall & ack_phase;
  assign shift_en      = scl_rise & receiving & ~ack_phase & (bitcnt < FULL);
  assign dev_byte_done = byte_done & (state == ST_DEV);
  assign dev_ok        = dev_match(shreg, strap) & ~wr_busy;
  assign ld_hi         = byte_done & (state == ST_WA_HI);
  assign ld_lo         = byte_done & (state == ST_WA_LO);
  assign adv           = byte_done & (state == ST_DATA);

  twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_hi(ld_hi),
    .load_lo(ld_lo),
    .advance(adv),
    .din    (shreg),
    .ptr    (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      ack_phase <= 1'b0;
      have_data <= 1'b0;
      sda_pull  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wr_commit <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt) begin
        state     <= ST_DEV;
        bitcnt    <= '0;
        ack_phase <= 1'b0;
        have_data <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_evt) begin
        wr_commit <= (state == ST_DATA) & have_data;
        state     <= ST_IDLE;
        bitcnt    <= '0;
        ack_phase <= 1'b0;
        have_data <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (ack_end) begin
        sda_pull  <= 1'b0;
        ack_phase <= 1'b0;
        bitcnt    <= '0;
      end else if (byte_done) begin
        case (state)
          ST_DEV: begin
            if (dev_ok) begin
              sda_pull  <= 1'b1;
              ack_phase <= 1'b1;
              state     <= is_read(shreg) ? ST_SKIP : ST_WA_HI;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_WA_HI: begin
            sda_pull  <= 1'b1;
            ack_phase <= 1'b1;
            state     <= ST_WA_LO;
          end
          ST_WA_LO: begin
            sda_pull  <= 1'b1;
            ack_phase <= 1'b1;
            state     <= ST_DATA;
          end
          ST_DATA: begin
            sda_pull  <= 1'b1;
            ack_phase <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ptr;
            mem_wdata <= shreg;
            have_data <= 1'b1;
          end
          default: state <= ST_SKIP;
        endcase
      end else if (shift_en) begin
        shreg  <= {shreg[6:0], sda_q};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_evt,
  input logic stop_evt,
  input logic dev_byte_done,
  input logic wr_busy,
  input logic sda_pull,
  input logic mem_we,
  input logic wr_commit
);

  // R11: pull enable moves only while synchronised SCL is low
  a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_q);

  // R5: each write strobe coincides with the acknowledge of its byte
  a_r5_we_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> sda_pull);

  // R8: device word finished while busy leaves the line released
  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_byte_done && wr_busy) |=> !sda_pull);

  // R7: commit only as the result of a stop
  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  // R10: a start always leaves the line released
  a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_q        (scl_q),
  .start_evt    (start_evt),
  .stop_evt     (stop_evt),
  .dev_byte_done(dev_byte_done),
  .wr_busy      (wr_busy),
  .sda_pull     (sda_pull),
  .mem_we       (mem_we),
  .wr_commit    (wr_commit)
);

// File: tb/twi_eeprom_slave_bench.sv
module twi_eeprom_slave_bench;

  localparam int AW = 14;
  localparam int PAGE = 64;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wr_busy = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_pull, mem_we, wr_commit;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  wire sda_line = sda_m & ~sda_pull;

  twi_eeprom_slave u_twi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap(strap), .wr_busy(wr_busy), .sda_pull(sda_pull),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_commit(wr_commit)
  );

  int checks = 0, fails = 0, commits = 0;
  int unsigned cyc = 0;
  bit done = 0;
  int got_q[$];
  int exp_q[$];

  always @(negedge clk) begin
    cyc++;
    if (mem_we) got_q.push_back(int'({mem_addr, mem_wdata}));
    if (wr_commit) commits++;
    if (!done && cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wt(Q/2);
    sda_m = 1'b1; wt(Q/2);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wt(Q/2);
    sda_m = 1'b0; wt(Q/2);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q/2);
      scl_m = 1'b1; wt(Q/2);
      chk(sda_pull == 1'b0, "R11", "pull during master bit", sda_pull, 0);
      wt(Q/2);
      scl_m = 1'b0; wt(Q/2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q/2);
    scl_m = 1'b1; wt(Q/2);
    chk(sda_pull == exp_ack, req, "ack slot", sda_pull, exp_ack);
    wt(Q/2);
    scl_m = 1'b0; wt(Q/2);
  endtask

  task automatic check_writes(input string req, input int commits_before, input int exp_commits);
    chk(got_q.size() == exp_q.size(), req, "write strobe count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[k]) chk(got_q[k] == exp_q[k], req, "address/data", got_q[k], exp_q[k]);
    chk(commits - commits_before == exp_commits, "R7", "commit pulses", commits - commits_before, exp_commits);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic write_txn(input logic [1:0] st, input logic [7:0] hi, input logic [7:0] lo,
                           input int n, input logic [7:0] seed, input bit exp_ack,
                           input string req, input string data_req);
    int base, pbase, c0;
    logic [7:0] d;
    c0 = commits;
    base = (hi * 256 + lo) % (1 << AW);
    pbase = (base / PAGE) * PAGE;
    bus_start();
    send_byte({5'b10100, st, 1'b0}, exp_ack, req);
    send_byte(hi, exp_ack, exp_ack ? "R4" : req);
    send_byte(lo, exp_ack, exp_ack ? "R4" : req);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 7);
      send_byte(d, exp_ack, exp_ack ? "R5" : req);
      if (exp_ack) exp_q.push_back((pbase + ((base % PAGE) + i) % PAGE) * 256 + d);
    end
    bus_stop();
    wt(4);
    check_writes(data_req, c0, (exp_ack && n > 0) ? 1 : 0);
  endtask

  initial begin
    int c0;
    wt(5);
    rst_n = 1'b1;
    wt(2);
    // R12 reset state
    chk(sda_pull == 1'b0, "R12", "sda_pull after reset", sda_pull, 0);
    chk(mem_we == 1'b0, "R12", "mem_we after reset", mem_we, 0);
    chk(wr_commit == 1'b0, "R12", "wr_commit after reset", wr_commit, 0);

    // R1 R4 R5 R7: single byte write, strap 10
    write_txn(2'b10, 8'h12, 8'h34, 1, 8'h5A, 1'b1, "R1", "R5");
    // R4: address bits above ADDR_W discarded
    write_txn(2'b10, 8'hC1, 8'h07, 2, 8'h33, 1'b1, "R1", "R4");
    // R6: page wrap from 0x13E
    write_txn(2'b10, 8'h01, 8'h3E, 4, 8'h90, 1'b1, "R1", "R6");
    // R7: stop right after address, no data
    write_txn(2'b10, 8'h00, 8'h10, 0, 8'h00, 1'b1, "R1", "R7");

    // R2: wrong prefix
    c0 = commits;
    bus_start();
    send_byte(8'hB4, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    send_byte(8'h55, 1'b0, "R2");
    bus_stop(); wt(4);
    check_writes("R2", c0, 0);

    // R3: strap mismatch, then match with strap changed
    write_txn(2'b01, 8'h00, 8'h20, 2, 8'h11, 1'b0, "R3", "R3");
    strap = 2'b01;
    wt(4);
    write_txn(2'b01, 8'h00, 8'h20, 1, 8'h11, 1'b1, "R3", "R3");
    strap = 2'b10;
    wt(4);

    // R9: read request acknowledged, then silence
    c0 = commits;
    bus_start();
    send_byte({5'b10100, 2'b10, 1'b1}, 1'b1, "R9");
    send_byte(8'hFF, 1'b0, "R9");
    bus_stop(); wt(4);
    check_writes("R9", c0, 0);

    // R8: busy refuses write and read
    wr_busy = 1'b1;
    write_txn(2'b10, 8'h00, 8'h40, 2, 8'h21, 1'b0, "R8", "R8");
    c0 = commits;
    bus_start();
    send_byte({5'b10100, 2'b10, 1'b1}, 1'b0, "R8");
    bus_stop(); wt(4);
    check_writes("R8", c0, 0);
    wr_busy = 1'b0;
    wt(4);
    write_txn(2'b10, 8'h00, 8'h40, 1, 8'h21, 1'b1, "R8", "R8");

    // R10: start in mid device byte, then full transfer
    bus_start();
    send_bits(8'hA4, 4);
    write_txn(2'b10, 8'h02, 8'h05, 2, 8'h6C, 1'b1, "R10", "R10");

    // R10: stop in mid data byte, nothing written or committed
    c0 = commits;
    bus_start();
    send_byte(8'hA4, 1'b1, "R10");
    send_byte(8'h03, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    send_bits(8'hC3, 3);
    bus_stop(); wt(4);
    check_writes("R10", c0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule